// File: doc/BRIEF.md
# Spike Address Scanner and Merger

This block gathers spike addresses from three origins and hands them one at a time to a single consumer. The first origin is a bank of local spiking cells. Each cell is represented by a sticky fire flag. A scanner steps through the flags one address per clock and wraps around without pause. When it finds a set flag, it enqueues that address and pulses a clear line so the flag drops. The second origin is a port carrying addresses from other boards. The third is a port carrying addresses injected by a host. Each origin has its own synchronous FIFO.

An output arbiter picks a non-empty FIFO and presents its head address with a 2-bit origin tag. The consumer takes it through a valid/ready handshake. Both input ports are valid/ready. A port's ready is low while its FIFO is full, and a word moves only in a cycle where valid and ready are both high.

On the output, the consumer may hold ready low for any time. While it does, the presented address and tag stay frozen, even if a higher-priority FIFO fills in the meantime. With 1000 sources scanned at one address per cycle, a full sweep takes 1000 cycles. At 100 MHz that is 10 µs, well inside a 100 µs sweep budget.

Top module: `spike_merge_scanner`

## Requirements
- R1: During reset, out_valid is 0 and ext_ready and host_ready are 1. After reset is released, all FIFOs are empty and the scan restarts at address 0, so a flag at address 0 is cleared (fire_clr[0]=1) in the first cycle after release.
- R2: The scanner visits addresses in increasing order and wraps from N_SRC-1 to 0. Any set flag is therefore found within N_SRC cycles, and flags set together leave in ascending address order after a reset.
- R3: When the scanner finds a set flag and the internal FIFO has room, it enqueues that address and raises exactly that one bit of fire_clr for one cycle.
- R4: When the internal FIFO is full, the scanner stalls on the set flag it has reached. It does not clear that flag and does not move on, so no spike is dropped.
- R5: ext_ready is 0 exactly when the external FIFO is full. Accepted addresses leave in arrival order.
- R6: host_ready is 0 exactly when the host FIFO is full. Accepted addresses leave in arrival order.
- R7: When a new choice is made, the arbiter serves internal before external before host.
- R8: out_origin is 0 for internal, 1 for external and 2 for host. The value 3 never appears.
- R9: While out_valid is 1 and out_ready is 0, out_addr and out_origin hold steady and out_valid stays 1.
- R10: Every accepted address is delivered exactly once. No address is delivered that was never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_flags | input | N_SRC | Sticky fire flag of each local source |
| fire_clr | output | N_SRC | One-cycle clear pulse for the flag just captured |
| ext_valid | input | 1 | External address offered |
| ext_addr | input | AW | External spike address |
| ext_ready | output | 1 | External FIFO can accept |
| host_valid | input | 1 | Host address offered |
| host_addr | input | AW | Host spike address |
| host_ready | output | 1 | Host FIFO can accept |
| out_valid | output | 1 | An address is presented |
| out_addr | output | AW | Presented spike address |
| out_origin | output | 2 | Origin tag of the presented address |
| out_ready | input | 1 | Consumer accepts the presented address |

## Verification
Two things can happen in the same cycle. The scanner can enqueue into the internal FIFO while the arbiter dequeues from it. A higher-priority FIFO can also become non-empty while a lower-priority address is held under back-pressure.

The first case is provoked by setting flags while out_ready stays high. The second is provoked by presenting a host address with out_ready low, then loading the external port and local flags behind it. A scoreboard of per-origin expected FIFOs judges every delivered address and tag. A recorded tag sequence confirms that the held host address goes out first, and that after it internal entries precede external ones, which precede the remaining host entry.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic [1:0] {
    ORG_INT  = 2'd0,
    ORG_EXT  = 2'd1,
    ORG_HOST = 2'd2
  } origin_e;
  localparam int NUM_ORG = 3;
endpackage

// File: rtl/spk_fifo.sv
module spk_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LASTP) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LASTP) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spk_scanner.sv
module spk_scanner #(
  parameter int N_SRC = 1000,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] flags,
  input  logic             q_full,
  output logic             push,
  output logic [AW-1:0]    addr,
  output logic [N_SRC-1:0] clr
);
  localparam logic [AW-1:0] LAST = AW'(N_SRC - 1);

  logic [AW-1:0] ptr_q;
  logic          hit;

  assign hit  = flags[ptr_q];
  assign push = rst_n && hit && !q_full;
  assign addr = ptr_q;

  always_comb begin
    clr = '0;
    clr[ptr_q] = push;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (!hit || !q_full)
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/spk_arbiter.sv
module spk_arbiter
  import spk_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_ORG-1:0]     empty,
  input  logic [NUM_ORG-1:0][AW-1:0] head,
  output logic [NUM_ORG-1:0]     pop,
  output logic                   out_valid,
  output logic [AW-1:0]          out_addr,
  output logic [1:0]             out_origin,
  input  logic                   out_ready
);
  logic    lock_q;
  origin_e held_q, pick, sel;

  always_comb begin
    if (!empty[ORG_INT])      pick = ORG_INT;
    else if (!empty[ORG_EXT]) pick = ORG_EXT;
    else                      pick = ORG_HOST;
  end

  assign sel        = lock_q ? held_q : pick;
  assign out_valid  = rst_n && (empty != '1);
  assign out_addr   = head[sel];
  assign out_origin = sel;

  always_comb begin
    pop = '0;
    pop[sel] = out_valid && out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      held_q <= ORG_INT;
    end else begin
      lock_q <= out_valid && !out_ready;
      held_q <= sel;
    end
  end
endmodule

// File: rtl/spike_merge_scanner.sv
module spike_merge_scanner
  import spk_pkg::*;
#(
  parameter int N_SRC = 1000,
  parameter int AW    = 10,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] fire_flags,
  output logic [N_SRC-1:0] fire_clr,
  input  logic             ext_valid,
  input  logic [AW-1:0]    ext_addr,
  output logic             ext_ready,
  input  logic             host_valid,
  input  logic [AW-1:0]    host_addr,
  output logic             host_ready,
  output logic             out_valid,
  output logic [AW-1:0]    out_addr,
  output logic [1:0]       out_origin,
  input  logic             out_ready
);
  logic [NUM_ORG-1:0]         q_push, q_pop, q_full, q_empty;
  logic [NUM_ORG-1:0][AW-1:0] q_din, q_head;
  logic                       scan_push;
  logic [AW-1:0]              scan_addr;
  logic                       int_full;

  spk_scanner #(.N_SRC(N_SRC), .AW(AW)) u_scan (
    .clk(clk), .rst_n(rst_n), .flags(fire_flags), .q_full(int_full),
    .push(scan_push), .addr(scan_addr), .clr(fire_clr)
  );

  assign q_push[ORG_INT]  = scan_push;
  assign q_din[ORG_INT]   = scan_addr;
  assign q_push[ORG_EXT]  = ext_valid;
  assign q_din[ORG_EXT]   = ext_addr;
  assign q_push[ORG_HOST] = host_valid;
  assign q_din[ORG_HOST]  = host_addr;
  assign int_full   = q_full[ORG_INT];
  assign ext_ready  = !q_full[ORG_EXT];
  assign host_ready = !q_full[ORG_HOST];

  for (genvar g = 0; g < NUM_ORG; g++) begin : g_q
    spk_fifo #(.W(AW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(q_push[g]), .din(q_din[g]),
      .full(q_full[g]), .pop(q_pop[g]), .dout(q_head[g]), .empty(q_empty[g])
    );
  end

  spk_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .empty(q_empty), .head(q_head), .pop(q_pop),
    .out_valid(out_valid), .out_addr(out_addr), .out_origin(out_origin),
    .out_ready(out_ready)
  );
endmodule

// File: rtl/spike_merge_scanner_chk.sv
module spike_merge_scanner_chk #(
  parameter int N_SRC = 1000,
  parameter int AW    = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] fire_flags,
  input logic [N_SRC-1:0] fire_clr,
  input logic             int_full,
  input logic             out_valid,
  input logic             out_ready,
  input logic [AW-1:0]    out_addr,
  input logic [1:0]       out_origin
);
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_clr)); // R3
  AST_CLR_ON_SET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_clr & ~fire_flags) == '0); // R3
  AST_NO_CLR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    int_full |-> (fire_clr == '0)); // R4
  AST_ORIGIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_origin != 2'd3)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_origin))); // R9
endmodule

bind spike_merge_scanner spike_merge_scanner_chk #(.N_SRC(N_SRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire_flags(fire_flags), .fire_clr(fire_clr),
  .int_full(int_full), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_origin(out_origin)
);

// File: tb/spike_merge_scanner_bench.sv
module spike_merge_scanner_bench;
  localparam int N  = 1000;
  localparam int AW = 10;
  localparam int D  = 4;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] flags = '0, set_vec = '0, fire_clr;
  logic ext_valid = 0, host_valid = 0, out_ready = 1;
  logic [AW-1:0] ext_addr = '0, host_addr = '0, out_addr;
  logic ext_ready, host_ready, out_valid;
  logic [1:0] out_origin;

  int checks = 0, fails = 0, delivered = 0, accepted = 0;
  logic [AW-1:0] exp_int[$], exp_ext[$], exp_host[$];
  int org_log[$];

  always #5 clk = ~clk;

  spike_merge_scanner #(.N_SRC(N), .AW(AW), .DEPTH(D)) u_spike_merge_scanner (
    .clk(clk), .rst_n(rst_n), .fire_flags(flags), .fire_clr(fire_clr),
    .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_ready(ext_ready),
    .host_valid(host_valid), .host_addr(host_addr), .host_ready(host_ready),
    .out_valid(out_valid), .out_addr(out_addr), .out_origin(out_origin),
    .out_ready(out_ready)
  );

  always @(posedge clk) flags <= (flags & ~fire_clr) | set_vec;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops per-origin expected FIFOs as the design delivers
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [AW-1:0] e;
      delivered++;
      org_log.push_back(int'(out_origin));
      case (out_origin)
        2'd0: if (exp_int.size() > 0)  begin e = exp_int.pop_front();  chk(out_addr == e, "R3 internal addr", out_addr, e); end
              else chk(0, "R10 unexpected internal", out_addr, -1);
        2'd1: if (exp_ext.size() > 0)  begin e = exp_ext.pop_front();  chk(out_addr == e, "R5 external addr", out_addr, e); end
              else chk(0, "R10 unexpected external", out_addr, -1);
        2'd2: if (exp_host.size() > 0) begin e = exp_host.pop_front(); chk(out_addr == e, "R6 host addr", out_addr, e); end
              else chk(0, "R10 unexpected host", out_addr, -1);
        default: chk(0, "R8 origin tag", out_origin, 0);
      endcase
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    exp_int.delete(); exp_ext.delete(); exp_host.delete(); org_log.delete();
    cyc(3);
    rst_n = 1;
  endtask

  task automatic set_flags(input logic [N-1:0] v);
    set_vec = v;
    cyc(1);
    set_vec = '0;
  endtask

  task automatic push_ext(input logic [AW-1:0] a);
    ext_valid = 1; ext_addr = a;
    do @(negedge clk); while (!ext_ready);
    exp_ext.push_back(a); accepted++;
    cyc(1);
    ext_valid = 0;
  endtask

  task automatic push_host(input logic [AW-1:0] a);
    host_valid = 1; host_addr = a;
    do @(negedge clk); while (!host_ready);
    exp_host.push_back(a); accepted++;
    cyc(1);
    host_valid = 0;
  endtask

  initial begin
    int cnt;
    logic [N-1:0] v;
    int exp_seq[6] = '{2, 0, 0, 1, 1, 2};
    cyc(1);
    // R1: reset state, flag 0 pending
    set_flags(N'(1));
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(ext_ready == 1 && host_ready == 1, "R1 ready in reset", {ext_ready, host_ready}, 3);
    @(posedge clk); #1 rst_n = 1;
    exp_int.delete(); exp_ext.delete(); exp_host.delete();
    @(negedge clk);
    chk(fire_clr[0] == 1, "R1 scan restarts at 0", fire_clr[0], 1);
    chk(out_valid == 0, "R1 empty after reset", out_valid, 0);
    exp_int.push_back(0); accepted++;
    @(negedge clk);
    chk(fire_clr == '0 && flags[0] == 0, "R3 single clear pulse", flags[0], 0);
    cyc(20);

    // R2: ascending order after reset
    do_reset();
    v = '0; v[5] = 1; v[3] = 1;
    exp_int.push_back(3); exp_int.push_back(5); accepted += 2;
    set_flags(v);
    cyc(30);
    chk(exp_int.size() == 0, "R2 order 3 then 5 delivered", exp_int.size(), 0);

    // R2: sweep bound
    v = '0; v[N-1] = 1;
    exp_int.push_back(AW'(N - 1)); accepted++;
    set_flags(v);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!fire_clr[N-1] && cnt < 3000);
    chk(cnt <= N, "R2 found within one sweep", cnt, N);
    cyc(10);

    // R4: stall on full internal FIFO
    do_reset();
    out_ready = 0;
    v = '0;
    for (int i = 10; i < 16; i++) begin v[i] = 1; exp_int.push_back(AW'(i)); accepted++; end
    set_flags(v);
    cyc(2 * N + 10);
    @(negedge clk);
    chk(flags[14] == 1 && flags[15] == 1, "R4 flags kept while full", {flags[15], flags[14]}, 3);
    chk(fire_clr == '0, "R4 no clear while full", $countones(fire_clr), 0);
    chk(out_valid == 1 && out_addr == 10, "R4 head is first capture", out_addr, 10);
    cyc(1);
    out_ready = 1;
    cyc(2 * N + 20);
    chk(exp_int.size() == 0, "R4 all six delivered", exp_int.size(), 0);

    // R5/R6: port back-pressure and order
    do_reset();
    out_ready = 0;
    for (int i = 0; i < D; i++) push_ext(AW'(300 + i));
    ext_valid = 1; ext_addr = 10'd399;
    @(negedge clk);
    chk(ext_ready == 0, "R5 ext_ready low when full", ext_ready, 0);
    cyc(1); ext_valid = 0;
    for (int i = 0; i < D; i++) push_host(AW'(400 + i));
    host_valid = 1; host_addr = 10'd499;
    @(negedge clk);
    chk(host_ready == 0, "R6 host_ready low when full", host_ready, 0);
    cyc(1); host_valid = 0;
    out_ready = 1;
    cyc(20);
    chk(exp_ext.size() == 0 && exp_host.size() == 0, "R5 R6 FIFO order drained",
        exp_ext.size() + exp_host.size(), 0);
    chk(org_log.size() == 2 * D && org_log[D-1] == 1 && org_log[D] == 2,
        "R7 external before host", org_log.size(), 2 * D);

    // R7/R9: held host address, then priority
    do_reset();
    out_ready = 0;
    push_host(10'd100); push_host(10'd101);
    @(negedge clk);
    chk(out_valid && out_origin == 2 && out_addr == 100, "R8 host tag", out_origin, 2);
    cyc(1);
    push_ext(10'd200); push_ext(10'd201);
    v = '0; v[500] = 1; v[501] = 1;
    exp_int.push_back(10'd500); exp_int.push_back(10'd501); accepted += 2;
    set_flags(v);
    cyc(N + 100);
    @(negedge clk);
    chk(out_origin == 2 && out_addr == 100, "R9 held under back-pressure", out_addr, 100);
    cyc(1);
    out_ready = 1;
    cyc(20);
    chk(org_log.size() == 6, "R7 six delivered", org_log.size(), 6);
    for (int i = 0; i < 6 && i < org_log.size(); i++)
      chk(org_log[i] == exp_seq[i], "R7 priority sequence", org_log[i], exp_seq[i]);

    // R10: overlap of scan enqueue and dequeue
    v = '0;
    for (int i = 700; i < 710; i++) begin v[i] = 1; exp_int.push_back(AW'(i)); accepted++; end
    set_flags(v);
    cyc(N + 50);
    chk(exp_int.size() + exp_ext.size() + exp_host.size() == 0, "R10 nothing lost",
        exp_int.size() + exp_ext.size() + exp_host.size(), 0);
    chk(delivered == accepted, "R10 delivered once each", delivered, accepted);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule